// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the software-facing half of an SMBus host. Software fills a small byte-wide register file with a target address, a command code and data bytes. It then writes a control byte that names a protocol and carries a start bit. The block turns that request into a series of byte-level operations for a separate bus engine: start condition, byte out, byte in with ACK or NACK, and stop. The engine handles the bit timing on the wires and answers each operation with a done pulse. With that pulse it reports whether the target acknowledged and whether arbitration was lost.

The block supports quick, byte, byte-data, word-data and block transfers. Block transfers move one payload byte at a time, and the sequencer waits for software between bytes. Outcomes land in a write-one-to-clear status register: normal completion, missing acknowledge, lost arbitration, or failure. Failure covers both an aborted transfer and an illegal block count. A kill request ends a running transfer.

Top module: `smbus_host_seq`

## Requirements
- R1: Writing offset 2 with bit 6 set, bit 1 clear and a protocol code in bits [4:2] of 0 (quick), 1 (byte), 2 (byte-data), 3 (word) or 5 (block) starts a transfer when host busy (status bit 0) is clear. Status reads busy at the next cycle. A start written while busy, or with any other protocol code, has no effect on the bus or on the running transfer.
- R2: Offsets are status 0, control 2, command 3, address 4, data0 5, data1 6, block byte 7. Offset 1 reads zero. All registers reset to zero.
- R3: Engine operation codes are 0 start, 1 write byte, 2 read byte, 3 stop. The address byte carries the 7-bit target in bits [7:1] and the direction (1 = read) in bit 0. A quick transfer is start, address byte with the direction bit from the address register, stop. A byte transfer is start, address byte, then either the command byte (write) or one read answered with NACK (read), then stop.
- R4: Byte-data and word writes send start, the address with bit 0 cleared, the command, data0, then data1 (word only), then stop.
- R5: Byte-data and word reads send start, the address with bit 0 cleared and the command, then a repeated start and the address with bit 0 set. The received bytes go to data0 and then data1 (word). Only the final read byte is answered with NACK.
- R6: A block write sends the data0 count after the command, then one payload byte taken from offset 7. After each payload byte, status bit 7 (byte done) is set and no further engine operation is issued until software clears it. Once the count is reached, a stop follows.
- R7: A block read, after the repeated start, reads a count byte into data0. A count of 0 or above 32 sets failed (status bit 4) and issues a stop without the interrupt bit. Otherwise each payload byte is placed at offset 7 and sets byte done.
- R8: In a block read, the payload byte read while control bit 5 is set is answered with NACK. After software clears byte done for that byte, a stop follows.
- R9: A missing acknowledge on any written byte sets device error (status bit 2) and issues a stop. Busy then clears and the interrupt bit stays clear.
- R10: Lost arbitration sets bus error (status bit 3), clears busy and releases the engine with no stop.
- R11: Writing control with bit 1 set while busy ends the transfer at once: the engine request drops, busy clears and failed is set.
- R12: After a successful stop, busy clears and the interrupt bit (status bit 1) is set. Registers that the protocol does not read into are left unchanged.
- R13: Writing status clears each of bits 7 to 1 where the written bit is 1. Busy is not affected.
- R14: A read of status while in-use (bit 6) is clear returns it clear and then sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| eng_req | output | 1 | Operation request to the bus engine, held until done |
| eng_op | output | 2 | Operation code: 0 start, 1 write, 2 read, 3 stop |
| eng_wbyte | output | 8 | Byte to transmit for a write operation |
| eng_rd_nack | output | 1 | Answer the byte being read with NACK |
| eng_done | input | 1 | One-cycle completion of the requested operation |
| eng_ack | input | 1 | Target acknowledged the written byte |
| eng_rbyte | input | 8 | Byte received by a read operation |
| eng_arb_lost | input | 1 | Arbitration was lost during the operation |

## Verification
A phase register that took a wrong branch shows up immediately in the logged engine operation stream. It appears as an extra or missing repeated start, a wrong direction bit in the address, or a NACK on the wrong read byte, and each is visible one operation after the fault. A lost error flag shows in the status byte read right after busy drops: device error without the interrupt bit, failed on a bad count, bus error with no stop in the log. Stall bugs in block mode show as engine operations logged while byte done is still set, and these are checked over several idle cycles.

// File: rtl/smbus_host_seq.sv
module smbus_host_seq #(
  parameter int MAX_BLOCK = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       eng_req,
  output logic [1:0] eng_op,
  output logic [7:0] eng_wbyte,
  output logic       eng_rd_nack,
  input  logic       eng_done,
  input  logic       eng_ack,
  input  logic [7:0] eng_rbyte,
  input  logic       eng_arb_lost
);
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;
  localparam logic [2:0] P_QUICK = 3'd0, P_BYTE = 3'd1, P_WORD = 3'd3, P_BLOCK = 3'd5;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START1, PH_ADDR1, PH_CMD, PH_WD0, PH_WD1, PH_START2, PH_ADDR2,
    PH_RD0, PH_RD1, PH_BCNT_W, PH_BLK_W, PH_BCNT_R, PH_BLK_R, PH_STOP, PH_WAIT
  } phase_t;

  phase_t     phase, nxt;
  logic [7:0] ctl, cmd, adr, d0, d1, blk, sent;
  logic [2:0] proto;
  logic       rw, err_pend, last_seen;
  logic       st_bd, st_inuse, st_fail, st_buserr, st_deverr, st_intr, busy;

  wire       ctl_wr   = reg_wr && reg_addr == 3'd2;
  wire [2:0] code     = reg_wdata[4:2];
  wire       proto_ok = code == 3'd0 || code == 3'd1 || code == 3'd2 || code == 3'd3 || code == 3'd5;
  wire       go       = ctl_wr && reg_wdata[6] && !reg_wdata[1] && proto_ok && !busy;
  wire       kill     = ctl_wr && reg_wdata[1] && busy;
  wire       bad_cnt  = eng_rbyte == 8'd0 || int'(eng_rbyte) > MAX_BLOCK;

  assign eng_req = phase != PH_IDLE && phase != PH_WAIT;

  always_comb begin
    case (phase)
      PH_START1, PH_START2: eng_op = OP_START;
      PH_ADDR1, PH_ADDR2, PH_CMD, PH_WD0, PH_WD1, PH_BCNT_W, PH_BLK_W: eng_op = OP_WRITE;
      PH_RD0, PH_RD1, PH_BCNT_R, PH_BLK_R: eng_op = OP_READ;
      default: eng_op = OP_STOP;
    endcase
  end

  always_comb begin
    case (phase)
      PH_ADDR1:           eng_wbyte = {adr[7:1], (proto == P_QUICK || proto == P_BYTE) ? rw : 1'b0};
      PH_ADDR2:           eng_wbyte = {adr[7:1], 1'b1};
      PH_CMD:             eng_wbyte = cmd;
      PH_WD0, PH_BCNT_W:  eng_wbyte = d0;
      PH_WD1:             eng_wbyte = d1;
      PH_BLK_W:           eng_wbyte = blk;
      default:            eng_wbyte = 8'd0;
    endcase
  end

  always_comb begin
    case (phase)
      PH_RD0:   eng_rd_nack = proto != P_WORD;
      PH_RD1:   eng_rd_nack = 1'b1;
      PH_BLK_R: eng_rd_nack = ctl[5];
      default:  eng_rd_nack = 1'b0;
    endcase
  end

  always_comb begin
    nxt = PH_STOP;
    case (phase)
      PH_START1: nxt = PH_ADDR1;
      PH_ADDR1:  if (proto == P_BYTE) nxt = rw ? PH_RD0 : PH_CMD;
                 else if (proto != P_QUICK) nxt = PH_CMD;
      PH_CMD:    if (proto == P_BLOCK) nxt = rw ? PH_START2 : PH_BCNT_W;
                 else if (proto != P_BYTE) nxt = rw ? PH_START2 : PH_WD0;
      PH_WD0:    if (proto == P_WORD) nxt = PH_WD1;
      PH_START2: nxt = PH_ADDR2;
      PH_ADDR2:  nxt = (proto == P_BLOCK) ? PH_BCNT_R : PH_RD0;
      PH_RD0:    if (proto == P_WORD) nxt = PH_RD1;
      PH_BCNT_R: if (!bad_cnt) nxt = PH_BLK_R;
      PH_BCNT_W: nxt = PH_BLK_W;
      PH_BLK_W, PH_BLK_R: nxt = PH_WAIT;
      default:   nxt = PH_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE; ctl <= '0; cmd <= '0; adr <= '0; d0 <= '0; d1 <= '0; blk <= '0;
      sent <= '0; proto <= '0; rw <= 1'b0; err_pend <= 1'b0; last_seen <= 1'b0;
      st_bd <= 1'b0; st_inuse <= 1'b0; st_fail <= 1'b0; st_buserr <= 1'b0;
      st_deverr <= 1'b0; st_intr <= 1'b0; busy <= 1'b0;
    end else begin
      if (reg_rd && reg_addr == 3'd0) st_inuse <= 1'b1;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin
            if (reg_wdata[7]) st_bd     <= 1'b0;
            if (reg_wdata[6]) st_inuse  <= 1'b0;
            if (reg_wdata[4]) st_fail   <= 1'b0;
            if (reg_wdata[3]) st_buserr <= 1'b0;
            if (reg_wdata[2]) st_deverr <= 1'b0;
            if (reg_wdata[1]) st_intr   <= 1'b0;
          end
          3'd2: ctl <= reg_wdata & 8'hBD;
          3'd3: cmd <= reg_wdata;
          3'd4: adr <= reg_wdata;
          3'd5: d0  <= reg_wdata;
          3'd6: d1  <= reg_wdata;
          3'd7: blk <= reg_wdata;
          default: ;
        endcase
      end
      if (go) begin
        busy <= 1'b1; proto <= code; rw <= adr[0]; phase <= PH_START1;
        err_pend <= 1'b0; sent <= '0;
      end else if (kill) begin
        busy <= 1'b0; st_fail <= 1'b1; phase <= PH_IDLE;
      end else if (eng_req && eng_done) begin
        if (eng_arb_lost) begin
          st_buserr <= 1'b1; busy <= 1'b0; phase <= PH_IDLE;
        end else if (eng_op == OP_WRITE && !eng_ack) begin
          st_deverr <= 1'b1; err_pend <= 1'b1; phase <= PH_STOP;
        end else if (phase == PH_STOP) begin
          busy <= 1'b0; phase <= PH_IDLE;
          if (!err_pend) st_intr <= 1'b1;
        end else begin
          phase <= nxt;
          case (phase)
            PH_RD0:    d0 <= eng_rbyte;
            PH_RD1:    d1 <= eng_rbyte;
            PH_BCNT_R: begin
              d0 <= eng_rbyte;
              if (bad_cnt) begin st_fail <= 1'b1; err_pend <= 1'b1; end
            end
            PH_BLK_R:  begin blk <= eng_rbyte; st_bd <= 1'b1; last_seen <= eng_rd_nack; end
            PH_BLK_W:  begin sent <= sent + 8'd1; st_bd <= 1'b1; end
            default: ;
          endcase
        end
      end else if (phase == PH_WAIT && !st_bd) begin
        if (rw) phase <= last_seen ? PH_STOP : PH_BLK_R;
        else    phase <= (sent >= d0) ? PH_STOP : PH_BLK_W;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {st_bd, st_inuse, 1'b0, st_fail, st_buserr, st_deverr, st_intr, busy};
      3'd2:    reg_rdata = ctl;
      3'd3:    reg_rdata = cmd;
      3'd4:    reg_rdata = adr;
      3'd5:    reg_rdata = d0;
      3'd6:    reg_rdata = d1;
      3'd7:    reg_rdata = blk;
      default: reg_rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       eng_req,
  input logic [1:0] eng_op,
  input logic       eng_done,
  input logic       eng_ack,
  input logic       eng_arb_lost,
  input logic       busy,
  input logic       st_fail,
  input logic       st_buserr,
  input logic       st_deverr
);
  wire ctl_wr  = reg_wr && reg_addr == 3'd2;
  wire kill_wr = ctl_wr && reg_wdata[1];
  wire ok_code = reg_wdata[4:2] == 3'd0 || reg_wdata[4:2] == 3'd1 || reg_wdata[4:2] == 3'd2 ||
                 reg_wdata[4:2] == 3'd3 || reg_wdata[4:2] == 3'd5;

  p_req_needs_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> busy);

  p_start_sets_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[6] && !reg_wdata[1] && ok_code && !busy) |=> (busy && eng_req && eng_op == 2'd0));

  p_kill_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_wr && busy) |=> (!busy && !eng_req && st_fail));

  p_arb_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && eng_arb_lost && !kill_wr) |=> (!eng_req && !busy && st_buserr));

  p_nack_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && eng_op == 2'd1 && !eng_ack && !eng_arb_lost && !kill_wr)
      |=> (eng_req && eng_op == 2'd3 && st_deverr));

  p_hold_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done && !kill_wr) |=> (eng_req && $stable(eng_op)));

  p_stop_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && eng_op == 2'd3 && !eng_arb_lost && !kill_wr) |=> (!busy && !eng_req));
endmodule

bind smbus_host_seq smbus_host_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .eng_req(eng_req), .eng_op(eng_op), .eng_done(eng_done), .eng_ack(eng_ack),
  .eng_arb_lost(eng_arb_lost), .busy(busy), .st_fail(st_fail), .st_buserr(st_buserr),
  .st_deverr(st_deverr)
);

// File: tb/test_smbus_host_seq.sv
`timescale 1ns/1ps
module test_smbus_host_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic eng_req, eng_rd_nack;
  logic [1:0] eng_op;
  logic [7:0] eng_wbyte;
  logic eng_done = 1'b0, eng_ack = 1'b0, eng_arb_lost = 1'b0;
  logic [7:0] eng_rbyte = '0;

  always #2.5 clk = ~clk;

  smbus_host_seq i_smbus_host_seq (.*);

  int checks = 0, failures = 0;
  logic [10:0] log_q [1024];
  logic [10:0] exp_q [32];
  logic [7:0] rq [1024];
  int nlog = 0, rq_i = 0, nexp = 0, wait_cnt = 0;
  int nack_at = -1, arb_at = -1;
  bit hold = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      eng_done = 1'b0; eng_arb_lost = 1'b0;
    end else if (eng_done) begin
      eng_done = 1'b0; eng_arb_lost = 1'b0;
    end else if (eng_req && !hold) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        log_q[nlog] = {eng_op, eng_op == 2'd2 ? eng_rd_nack : 1'b0, eng_op == 2'd1 ? eng_wbyte : 8'd0};
        eng_ack = (nlog != nack_at);
        eng_arb_lost = (nlog == arb_at);
        if (eng_op == 2'd2) begin eng_rbyte = rq[rq_i]; rq_i++; end
        eng_done = 1'b1;
        if (nlog < 1023) nlog++;
        wait_cnt = $urandom_range(0, 2);
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    do peek(3'd0, s); while (s[0]);
  endtask

  task automatic wait_bd();
    logic [7:0] s;
    do peek(3'd0, s); while (!s[7] && s[0]);
  endtask

  function automatic logic [10:0] ent(input logic [1:0] op, input logic n, input logic [7:0] b);
    return {op, n, b};
  endfunction

  task automatic push(input logic [1:0] op, input logic n, input logic [7:0] b);
    exp_q[nexp] = ent(op, n, b); nexp++;
  endtask

  task automatic build_exp(input int code, input logic [6:0] a, input logic rw,
                           input logic [7:0] c, input logic [7:0] x0, input logic [7:0] x1);
    nexp = 0;
    push(0, 0, 0);
    if (code == 0) push(1, 0, {a, rw});
    else if (code == 1) begin
      push(1, 0, {a, rw});
      if (rw) push(2, 1, 0); else push(1, 0, c);
    end else begin
      push(1, 0, {a, 1'b0}); push(1, 0, c);
      if (rw) begin
        push(0, 0, 0); push(1, 0, {a, 1'b1});
        if (code == 3) begin push(2, 0, 0); push(2, 1, 0); end
        else push(2, 1, 0);
      end else begin
        push(1, 0, x0);
        if (code == 3) push(1, 0, x1);
      end
    end
    push(3, 0, 0);
  endtask

  task automatic cmp_log(input string r, input int base);
    int bad = 0;
    chk({r, " op count"}, nlog - base, nexp);
    for (int i = 0; i < nexp; i++) if (log_q[base + i] !== exp_q[i]) bad++;
    chk({r, " op mismatches"}, bad, 0);
  endtask

  task automatic setup(input logic [6:0] a, input logic rw, input logic [7:0] c,
                       input logic [7:0] x0, input logic [7:0] x1);
    wr(3'd4, {a, rw}); wr(3'd3, c); wr(3'd5, x0); wr(3'd6, x1); wr(3'd0, 8'hFE);
  endtask

  initial begin
    logic [7:0] v, s;
    int base;
    logic [7:0] bw [3];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      peek(i[2:0], v); chk("R2 reset value", v, 0);
    end

    // R1 unsupported protocol code 4 does nothing
    base = nlog;
    setup(7'h11, 1'b0, 8'h22, 8'h33, 8'h44);
    wr(3'd2, 8'h50);
    repeat (5) @(negedge clk);
    peek(3'd0, s); chk("R1 bad code busy", s[0], 0);
    chk("R1 bad code no ops", nlog - base, 0);

    // R1 start while busy ignored
    hold = 1'b1; base = nlog;
    setup(7'h15, 1'b0, 8'h01, 8'h02, 8'h03);
    wr(3'd2, 8'h40);
    peek(3'd0, s); chk("R1 busy after start", s[0], 1);
    wr(3'd2, 8'h4C);
    peek(3'd0, s); chk("R1 still busy", s[0], 1);
    hold = 1'b0;
    wait_idle();
    build_exp(0, 7'h15, 1'b0, 0, 0, 0); cmp_log("R1 second start ignored", base);

    // R13 busy unaffected by status clear
    hold = 1'b1;
    wr(3'd2, 8'h40);
    wr(3'd0, 8'hFF);
    peek(3'd0, s); chk("R13 busy kept", s, 8'h01);
    hold = 1'b0;
    wait_idle();
    peek(3'd0, s); chk("R12 completion status", s, 8'h02);
    wr(3'd0, 8'hFF);
    peek(3'd0, s); chk("R13 w1c clears", s, 8'h00);

    // R11 kill
    hold = 1'b1; base = nlog;
    wr(3'd2, 8'h48);
    wr(3'd2, 8'h02);
    peek(3'd0, s); chk("R11 kill status", s, 8'h10);
    hold = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 no ops after kill", nlog - base, 0);

    // R9 nack on address byte
    base = nlog; nack_at = base + 1;
    setup(7'h2C, 1'b0, 8'h9A, 8'h5B, 8'h00);
    wr(3'd2, 8'h48); wait_idle();
    nexp = 0; push(0, 0, 0); push(1, 0, {7'h2C, 1'b0}); push(3, 0, 0);
    cmp_log("R9 nack address", base);
    peek(3'd0, s); chk("R9 status dev err", s, 8'h04);

    // R9 nack on data byte
    base = nlog; nack_at = base + 3;
    setup(7'h2C, 1'b0, 8'h9A, 8'h5B, 8'h00);
    wr(3'd2, 8'h48); wait_idle();
    nexp = 0; push(0, 0, 0); push(1, 0, {7'h2C, 1'b0}); push(1, 0, 8'h9A); push(1, 0, 8'h5B); push(3, 0, 0);
    cmp_log("R9 nack data", base);
    peek(3'd0, s); chk("R9 status data nack", s, 8'h04);
    nack_at = -1;

    // R10 arbitration lost on command byte
    base = nlog; arb_at = base + 2;
    setup(7'h40, 1'b0, 8'h12, 8'h34, 8'h56);
    wr(3'd2, 8'h4C); wait_idle();
    nexp = 0; push(0, 0, 0); push(1, 0, {7'h40, 1'b0}); push(1, 0, 8'h12);
    cmp_log("R10 no stop", base);
    peek(3'd0, s); chk("R10 status bus err", s, 8'h08);
    arb_at = -1;

    // R6 block write, three bytes
    base = nlog;
    bw[0] = 8'hA1; bw[1] = 8'hB2; bw[2] = 8'hC3;
    setup(7'h2A, 1'b0, 8'h77, 8'd3, 8'h00);
    wr(3'd7, bw[0]);
    wr(3'd2, 8'h54);
    for (int i = 0; i < 3; i++) begin
      int n;
      wait_bd();
      n = nlog;
      repeat (5) @(negedge clk);
      chk("R6 stall while byte done", nlog - n, 0);
      if (i < 2) wr(3'd7, bw[i + 1]);
      wr(3'd0, 8'h80);
    end
    wait_idle();
    nexp = 0; push(0, 0, 0); push(1, 0, 8'h54); push(1, 0, 8'h77); push(1, 0, 8'd3);
    push(1, 0, bw[0]); push(1, 0, bw[1]); push(1, 0, bw[2]); push(3, 0, 0);
    cmp_log("R6 block write", base);
    peek(3'd0, s); chk("R6 status", s, 8'h02);

    // R7 R8 block read, count 3
    base = nlog;
    rq[rq_i] = 8'd3; rq[rq_i + 1] = 8'h5E; rq[rq_i + 2] = 8'h6F; rq[rq_i + 3] = 8'h70;
    setup(7'h31, 1'b1, 8'h10, 8'h00, 8'h00);
    wr(3'd2, 8'h14);
    wr(3'd2, 8'h54);
    for (int i = 0; i < 3; i++) begin
      logic [7:0] want;
      want = (i == 0) ? 8'h5E : (i == 1) ? 8'h6F : 8'h70;
      wait_bd();
      peek(3'd7, v); chk("R7 payload byte", v, want);
      if (i == 1) wr(3'd2, 8'h34);
      wr(3'd0, 8'h80);
    end
    wait_idle();
    nexp = 0; push(0, 0, 0); push(1, 0, 8'h62); push(1, 0, 8'h10); push(0, 0, 0); push(1, 0, 8'h63);
    push(2, 0, 0); push(2, 0, 0); push(2, 0, 0); push(2, 1, 0); push(3, 0, 0);
    cmp_log("R8 block read last nack", base);
    peek(3'd5, v); chk("R7 count in data0", v, 3);
    peek(3'd0, s); chk("R12 block read status", s, 8'h02);

    // R7 illegal counts 0 and 33
    for (int k = 0; k < 2; k++) begin
      base = nlog;
      rq[rq_i] = (k == 0) ? 8'd0 : 8'd33;
      setup(7'h31, 1'b1, 8'h10, 8'h00, 8'h00);
      wr(3'd2, 8'h54); wait_idle();
      nexp = 0; push(0, 0, 0); push(1, 0, 8'h62); push(1, 0, 8'h10); push(0, 0, 0); push(1, 0, 8'h63);
      push(2, 0, 0); push(3, 0, 0);
      cmp_log("R7 bad count", base);
      peek(3'd0, s); chk("R7 bad count status", s, 8'h10);
    end

    // R3 R4 R5 R12 random short transfers
    for (int t = 0; t < 24; t++) begin
      int code;
      logic [6:0] a;
      logic rw;
      logic [7:0] c, x0, x1, e0, e1;
      code = $urandom_range(0, 3);
      a = 7'($urandom); rw = 1'($urandom); c = 8'($urandom); x0 = 8'($urandom); x1 = 8'($urandom);
      base = nlog;
      rq[rq_i] = 8'($urandom); rq[rq_i + 1] = 8'($urandom);
      e0 = (rw && code != 0) ? rq[rq_i] : x0;
      e1 = (rw && code == 3) ? rq[rq_i + 1] : x1;
      setup(a, rw, c, x0, x1);
      wr(3'd2, 8'h40 | 8'(code << 2)); wait_idle();
      build_exp(code, a, rw, c, x0, x1);
      cmp_log(code < 2 ? "R3 sequence" : (rw ? "R5 sequence" : "R4 sequence"), base);
      peek(3'd5, v); chk("R5 data0 result", v, e0);
      peek(3'd6, v); chk("R5 data1 result", v, e1);
      peek(3'd3, v); chk("R12 command unchanged", v, c);
      peek(3'd0, s); chk("R12 status intr", s, 8'h02);
    end

    // R14 in-use semaphore
    rd(3'd0, s); chk("R14 first read", s[6], 0);
    rd(3'd0, s); chk("R14 second read", s[6], 1);
    wr(3'd0, 8'h40);
    peek(3'd0, s); chk("R13 in-use cleared", s[6], 0);

    finish_run();
  end
endmodule